// File: doc/BRIEF.md
# Serial audio-link output frame formatter

This block assembles the outgoing frame of a serial audio codec link and shifts it out one bit per bit clock. Each frame carries a 16-bit tag slot followed by twelve 20-bit slots: the command address, command data, left and right playback samples, a modem DAC sample, six reserved slots and a general-purpose-output slot. The host side presents the slot contents and their valid flags on parallel inputs. The block samples them once per frame, in the cycle where `load_o` is high.

The tag slot flags which of the twelve slots carry data. Playback samples are cut to a fixed resolution set by a parameter. The modem sample is cut to a resolution selected by an input. In every case the unused low bits go out as zeros. Slot 12 is not taken from the host directly. It mirrors the last value written to the general-purpose-output codec register (address 0x54 by default) through the command slots. It starts one frame after the write and keeps going until a reset.

Top module: `aclink_tx_framer`

## Requirements
- R1: A frame is 256 bits, sent MSB first: slot 0 is 16 bits, then slots 1..12 are 20 bits each. `load_o` is high for one bit clock in every 256. The inputs present in that cycle form the frame whose first bit appears on `sdata_o` in the next cycle.
- R2: `sync_o` is high for exactly the 16 bit times of slot 0 and low for the other 240.
- R3: Slot 0 bit 15 is the OR of the slot tags. Bits 14..3 are the valid tags of slots 1..12, in that order. Bits 2..0 are zero.
- R4: Slot 1 is {read flag, 7-bit address, 12 zeros} and is tagged when `cmd_valid_i` is high. Slot 2 is {16-bit data, 4 zeros}; it is tagged and carries data only for a valid write (`cmd_rd_i` low). Otherwise slot 2 is zero.
- R5: Slots 3 and 4 keep the top `PCM_RES` bits of the sample and zero the rest. An untagged sample slot is all zeros.
- R6: Slot 5 keeps the top 16, 18 or 20 bits of the modem sample for `modem_res_i` = 00, 01 or 10 respectively. The code 11 acts as 16. The rest is zeros, and the slot is zeros when untagged.
- R7: Slots 6..11 and their tags are always zero.
- R8: After `rst_ni` low, or a one-cycle `cold_rst_i` pulse, slot 12 is untagged and all zeros until the next general-purpose-output write.
- R9: A valid write to address `GPO_ADDR` in frame n puts its data in slot 12 of frame n+1, tagged valid. Reads of that address, and writes to other addresses, leave slot 12 unchanged.
- R10: Once tagged, slot 12 stays tagged in every frame and carries the latest written value as {16 data bits, 4 zero bits}.
- R11: While in reset, `sdata_o` and `sync_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock; outputs change on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cold_rst_i | input | 1 | Synchronous link cold reset; clears slot 12 state |
| cmd_valid_i | input | 1 | Command slot pair holds a request |
| cmd_rd_i | input | 1 | 1 = register read, 0 = register write |
| cmd_addr_i | input | 7 | Codec register address |
| cmd_data_i | input | 16 | Codec register write data |
| pcm_l_valid_i | input | 1 | Left playback sample valid |
| pcm_l_i | input | 20 | Left playback sample, MSB justified |
| pcm_r_valid_i | input | 1 | Right playback sample valid |
| pcm_r_i | input | 20 | Right playback sample, MSB justified |
| modem_valid_i | input | 1 | Modem sample valid |
| modem_res_i | input | 2 | Modem resolution: 00=16, 01=18, 10=20, 11=16 bits |
| modem_i | input | 20 | Modem DAC sample, MSB justified |
| load_o | output | 1 | Inputs are sampled for the next frame in this cycle |
| sync_o | output | 1 | Frame sync, high during slot 0 |
| sdata_o | output | 1 | Serial frame data |

## Verification
The bench builds the block with `PCM_RES` = 18 rather than the default 20. At 20 bits, slots 3 and 4 would pass every bit through unchanged. At 18, the truncation of the two low bits of both playback slots becomes visible on the wire. `GPO_ADDR` keeps its default 0x54. The random commands aim at that address about half the time, so that writes to it, reads of it and writes to nearby addresses all occur often.

// File: rtl/aclink_tx_pkg.sv
package aclink_tx_pkg;
  localparam int TAG_W   = 16;
  localparam int SLOT_W  = 20;
  localparam int N_SLOTS = 12;
  localparam int FRAME_W = TAG_W + N_SLOTS * SLOT_W;
  localparam int CNT_W   = $clog2(FRAME_W);

  typedef enum logic [1:0] {
    RES_16  = 2'b00,
    RES_18  = 2'b01,
    RES_20  = 2'b10,
    RES_RSV = 2'b11
  } modem_res_e;

  // keep the top 'bits' positions of a slot
  function automatic logic [SLOT_W-1:0] msb_mask(input int bits);
    logic [SLOT_W-1:0] m;
    for (int i = 0; i < SLOT_W; i++) m[i] = (i >= SLOT_W - bits);
    return m;
  endfunction
endpackage

// File: rtl/aclink_bit_timer.sv
module aclink_bit_timer
  import aclink_tx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             load_o,
  output logic             sync_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [CNT_W-1:0] cnt_q;

  // reset to the last bit so the first edge loads a frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= LAST;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign load_o = (cnt_q == LAST);
  assign sync_o = (cnt_q < CNT_W'(TAG_W));
endmodule

// File: rtl/aclink_gpo_slot.sv
module aclink_gpo_slot #(
  parameter int                ADDR_W   = 7,
  parameter int                DATA_W   = 16,
  parameter logic [ADDR_W-1:0] GPO_ADDR = 7'h54
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cold_rst_i,
  input  logic              load_i,
  input  logic              cmd_valid_i,
  input  logic              cmd_rd_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  logic hit;
  assign hit = load_i && cmd_valid_i && !cmd_rd_i && (cmd_addr_i == GPO_ADDR);

  // cold reset wins over a same-cycle write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (cold_rst_i) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (hit) begin
      valid_o <= 1'b1;
      data_o  <= cmd_data_i;
    end
  end
endmodule

// File: rtl/aclink_frame_packer.sv
module aclink_frame_packer
  import aclink_tx_pkg::*;
#(
  parameter int ADDR_W  = 7,
  parameter int DATA_W  = 16,
  parameter int PCM_RES = 20
) (
  input  logic              cmd_valid_i,
  input  logic              cmd_rd_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic              pcm_l_valid_i,
  input  logic [SLOT_W-1:0] pcm_l_i,
  input  logic              pcm_r_valid_i,
  input  logic [SLOT_W-1:0] pcm_r_i,
  input  logic              modem_valid_i,
  input  logic [1:0]        modem_res_i,
  input  logic [SLOT_W-1:0] modem_i,
  input  logic              gpo_valid_i,
  input  logic [DATA_W-1:0] gpo_data_i,
  output logic [FRAME_W-1:0] frame_o
);
  localparam logic [SLOT_W-1:0] PCM_MASK = msb_mask(PCM_RES);
  localparam logic [SLOT_W-1:0] M16      = msb_mask(16);
  localparam logic [SLOT_W-1:0] M18      = msb_mask(18);
  localparam logic [SLOT_W-1:0] M20      = msb_mask(20);

  logic [SLOT_W-1:0] slot_d [N_SLOTS+1];
  logic [N_SLOTS:1]  tag_v;
  logic [SLOT_W-1:0] modem_mask;
  logic [TAG_W-1:0]  tag_word;

  always_comb begin
    case (modem_res_e'(modem_res_i))
      RES_18:  modem_mask = M18;
      RES_20:  modem_mask = M20;
      default: modem_mask = M16;
    endcase
  end

  always_comb begin
    for (int s = 0; s <= N_SLOTS; s++) slot_d[s] = '0;
    tag_v = '0;

    tag_v[1] = cmd_valid_i;
    if (cmd_valid_i) begin
      slot_d[1][SLOT_W-1]             = cmd_rd_i;
      slot_d[1][SLOT_W-2 -: ADDR_W]   = cmd_addr_i;
    end
    tag_v[2] = cmd_valid_i && !cmd_rd_i;
    if (tag_v[2]) slot_d[2][SLOT_W-1 -: DATA_W] = cmd_data_i;

    tag_v[3] = pcm_l_valid_i;
    if (pcm_l_valid_i) slot_d[3] = pcm_l_i & PCM_MASK;
    tag_v[4] = pcm_r_valid_i;
    if (pcm_r_valid_i) slot_d[4] = pcm_r_i & PCM_MASK;
    tag_v[5] = modem_valid_i;
    if (modem_valid_i) slot_d[5] = modem_i & modem_mask;

    tag_v[N_SLOTS] = gpo_valid_i;
    if (gpo_valid_i) slot_d[N_SLOTS][SLOT_W-1 -: DATA_W] = gpo_data_i;
  end

  always_comb begin
    tag_word = '0;
    tag_word[TAG_W-1] = |tag_v;
    for (int s = 1; s <= N_SLOTS; s++) tag_word[TAG_W-1-s] = tag_v[s];
  end

  assign frame_o[FRAME_W-1 -: TAG_W] = tag_word;
  for (genvar s = 1; s <= N_SLOTS; s++) begin : g_slot
    assign frame_o[FRAME_W-TAG_W-1-(s-1)*SLOT_W -: SLOT_W] = slot_d[s];
  end
endmodule

// File: rtl/aclink_shifter.sv
module aclink_shifter
  import aclink_tx_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               sdata_o
);
  logic [FRAME_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '0;
    else if (load_i) sh_q <= frame_i;
    else             sh_q <= {sh_q[FRAME_W-2:0], 1'b0};
  end

  assign sdata_o = sh_q[FRAME_W-1];
endmodule

// File: rtl/aclink_tx_framer.sv
module aclink_tx_framer
  import aclink_tx_pkg::*;
#(
  parameter int                ADDR_W   = 7,
  parameter int                DATA_W   = 16,
  parameter int                PCM_RES  = 20,
  parameter logic [ADDR_W-1:0] GPO_ADDR = 7'h54
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cold_rst_i,
  input  logic              cmd_valid_i,
  input  logic              cmd_rd_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic              pcm_l_valid_i,
  input  logic [19:0]       pcm_l_i,
  input  logic              pcm_r_valid_i,
  input  logic [19:0]       pcm_r_i,
  input  logic              modem_valid_i,
  input  logic [1:0]        modem_res_i,
  input  logic [19:0]       modem_i,
  output logic              load_o,
  output logic              sync_o,
  output logic              sdata_o
);
  logic [CNT_W-1:0]   cnt_q;
  logic               gpo_valid_q;
  logic [DATA_W-1:0]  gpo_data_q;
  logic [FRAME_W-1:0] frame_d;

  aclink_bit_timer u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_o  (cnt_q),
    .load_o (load_o),
    .sync_o (sync_o)
  );

  aclink_gpo_slot #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .GPO_ADDR (GPO_ADDR)
  ) u_gpo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cold_rst_i  (cold_rst_i),
    .load_i      (load_o),
    .cmd_valid_i (cmd_valid_i),
    .cmd_rd_i    (cmd_rd_i),
    .cmd_addr_i  (cmd_addr_i),
    .cmd_data_i  (cmd_data_i),
    .valid_o     (gpo_valid_q),
    .data_o      (gpo_data_q)
  );

  aclink_frame_packer #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .PCM_RES (PCM_RES)
  ) u_pack (
    .cmd_valid_i   (cmd_valid_i),
    .cmd_rd_i      (cmd_rd_i),
    .cmd_addr_i    (cmd_addr_i),
    .cmd_data_i    (cmd_data_i),
    .pcm_l_valid_i (pcm_l_valid_i),
    .pcm_l_i       (pcm_l_i),
    .pcm_r_valid_i (pcm_r_valid_i),
    .pcm_r_i       (pcm_r_i),
    .modem_valid_i (modem_valid_i),
    .modem_res_i   (modem_res_i),
    .modem_i       (modem_i),
    .gpo_valid_i   (gpo_valid_q),
    .gpo_data_i    (gpo_data_q),
    .frame_o       (frame_d)
  );

  aclink_shifter u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_o),
    .frame_i (frame_d),
    .sdata_o (sdata_o)
  );
endmodule

module aclink_tx_framer_chk
  import aclink_tx_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cold_rst_i,
  input logic             load_o,
  input logic             sync_o,
  input logic             sdata_o,
  input logic [CNT_W-1:0] cnt_q,
  input logic             gpo_valid_q
);
  logic [CNT_W-1:0] sync_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sync_run <= '0;
    else if (sync_o) sync_run <= sync_run + 1'b1;
    else             sync_run <= '0;
  end

  // R1
  load_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);

  // R2
  sync_after_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> sync_o);

  // R2
  sync_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sync_o) |-> (sync_run == CNT_W'(TAG_W)));

  // R3
  tag_low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q >= CNT_W'(TAG_W - 3) && cnt_q < CNT_W'(TAG_W)) |-> !sdata_o);

  // R7
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q >= CNT_W'(TAG_W + 5 * SLOT_W) && cnt_q < CNT_W'(TAG_W + 11 * SLOT_W))
      |-> !sdata_o);

  // R8
  cold_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cold_rst_i |=> !gpo_valid_q);

  // R10
  gpo_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gpo_valid_q && !cold_rst_i) |=> gpo_valid_q);

  // R10
  gpo_pad_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q >= CNT_W'(FRAME_W - 4)) |-> !sdata_o);
endmodule

bind aclink_tx_framer aclink_tx_framer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cold_rst_i  (cold_rst_i),
  .load_o      (load_o),
  .sync_o      (sync_o),
  .sdata_o     (sdata_o),
  .cnt_q       (cnt_q),
  .gpo_valid_q (gpo_valid_q)
);

// File: tb/aclink_tx_framer_test.sv
module aclink_tx_framer_test;
  localparam int PCM_RES = 18;

  logic clk_i = 1'b0;
  always #5 clk_i = ~clk_i;

  logic        rst_ni, cold_rst_i;
  logic        cmd_valid_i, cmd_rd_i;
  logic [6:0]  cmd_addr_i;
  logic [15:0] cmd_data_i;
  logic        pcm_l_valid_i, pcm_r_valid_i, modem_valid_i;
  logic [19:0] pcm_l_i, pcm_r_i, modem_i;
  logic [1:0]  modem_res_i;
  logic        load_o, sync_o, sdata_o;

  aclink_tx_framer #(.PCM_RES(PCM_RES)) uut (.*);

  int n_run = 0, n_fail = 0;
  logic        m_gv = 1'b0;
  logic [15:0] m_gd = '0;

  function automatic logic [19:0] keep(input logic [19:0] v, input int bits);
    return v & (20'hFFFFF << (20 - bits));
  endfunction

  // expected frame from current inputs and slot 12 model
  function automatic logic [255:0] exp_frame();
    logic [255:0] f = '0;
    logic [19:0] s [1:12];
    logic [12:1] t = '0;
    int mres;
    for (int k = 1; k <= 12; k++) s[k] = '0;
    t[1] = cmd_valid_i;
    if (cmd_valid_i) s[1] = {cmd_rd_i, cmd_addr_i, 12'h000};
    t[2] = cmd_valid_i && !cmd_rd_i;
    if (t[2]) s[2] = {cmd_data_i, 4'h0};
    t[3] = pcm_l_valid_i;
    if (t[3]) s[3] = keep(pcm_l_i, PCM_RES);
    t[4] = pcm_r_valid_i;
    if (t[4]) s[4] = keep(pcm_r_i, PCM_RES);
    mres = (modem_res_i == 2'b01) ? 18 : (modem_res_i == 2'b10) ? 20 : 16;
    t[5] = modem_valid_i;
    if (t[5]) s[5] = keep(modem_i, mres);
    t[12] = m_gv;
    if (m_gv) s[12] = {m_gd, 4'h0};
    f[255] = |t;
    for (int k = 1; k <= 12; k++) begin
      f[255 - k] = t[k];
      f[239 - 20 * (k - 1) -: 20] = s[k];
    end
    return f;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // at a negedge with load_o high: drive done by caller, then capture frame
  task automatic run_frame(input string req, input int cold_at);
    logic [255:0] e, cap;
    bit sync_ok = 1'b1;
    logic wr_hit;
    e = exp_frame();
    wr_hit = cmd_valid_i && !cmd_rd_i && (cmd_addr_i == 7'h54);
    cap = '0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk_i);
      cap[255 - i] = sdata_o;
      if (sync_o !== (i < 16)) sync_ok = 1'b0;
      cold_rst_i = (i == cold_at);
    end
    cold_rst_i = 1'b0;
    if (wr_hit) begin m_gv = 1'b1; m_gd = cmd_data_i; end
    if (cold_at >= 0) begin m_gv = 1'b0; m_gd = '0; end
    chk(cap === e, req, cap, e);
    chk(sync_ok, "R2 sync window", 256'(sync_ok), 256'(1));
    chk(load_o === 1'b1, "R1 load period", 256'(load_o), 256'(1));
  endtask

  task automatic idle_inputs();
    cmd_valid_i = 0; cmd_rd_i = 0; cmd_addr_i = '0; cmd_data_i = '0;
    pcm_l_valid_i = 0; pcm_r_valid_i = 0; modem_valid_i = 0;
    pcm_l_i = '0; pcm_r_i = '0; modem_i = '0; modem_res_i = 2'b00;
  endtask

  task automatic rand_inputs();
    cmd_valid_i   = 1'($urandom);
    cmd_rd_i      = 1'($urandom);
    cmd_addr_i    = ($urandom % 2) ? 7'h54 : 7'($urandom);
    cmd_data_i    = 16'($urandom);
    pcm_l_valid_i = 1'($urandom);
    pcm_r_valid_i = 1'($urandom);
    modem_valid_i = 1'($urandom);
    pcm_l_i       = 20'($urandom);
    pcm_r_i       = 20'($urandom);
    modem_i       = 20'($urandom);
    modem_res_i   = 2'($urandom);
  endtask

  initial begin
    #(200000 * 10);
    n_run++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0C4A));
    rst_ni = 1'b0; cold_rst_i = 1'b0;
    idle_inputs();
    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk(sdata_o === 1'b0, "R11 sdata in reset", 256'(sdata_o), 256'(0));
    chk(sync_o === 1'b0, "R11 sync in reset", 256'(sync_o), 256'(0));
    rst_ni = 1'b1;
    chk(load_o === 1'b1, "R1 first load", 256'(load_o), 256'(1));

    // R8 idle frame after reset: slot 12 untagged
    run_frame("R8 idle after reset", -1);

    // R9 write to 0x54, plus R5 truncation and R6 16-bit modem
    cmd_valid_i = 1; cmd_rd_i = 0; cmd_addr_i = 7'h54; cmd_data_i = 16'hA5C3;
    pcm_l_valid_i = 1; pcm_l_i = 20'hFFFFF;
    pcm_r_valid_i = 1; pcm_r_i = 20'h12347;
    modem_valid_i = 1; modem_i = 20'hABCDF; modem_res_i = 2'b00;
    run_frame("R4 R5 R6 write frame", -1);

    idle_inputs();
    run_frame("R9 slot12 next frame", -1);

    // R9 read of 0x54 and write elsewhere leave slot 12 alone
    cmd_valid_i = 1; cmd_rd_i = 1; cmd_addr_i = 7'h54; cmd_data_i = 16'h1111;
    run_frame("R9 read ignored", -1);
    cmd_rd_i = 0; cmd_addr_i = 7'h52; cmd_data_i = 16'h2222;
    run_frame("R9 other addr ignored", -1);
    idle_inputs();
    run_frame("R10 slot12 sticky", -1);

    // R6 remaining resolutions, R7 reserved zero
    for (int r = 1; r < 4; r++) begin
      idle_inputs();
      modem_valid_i = 1; modem_i = 20'hFFFFF; modem_res_i = 2'(r);
      run_frame("R6 modem resolution R7", -1);
    end

    // R10 new value replaces the old one
    idle_inputs();
    cmd_valid_i = 1; cmd_addr_i = 7'h54; cmd_data_i = 16'h0FF0;
    run_frame("R10 rewrite", -1);
    idle_inputs();
    run_frame("R10 latest value", -1);

    // R8 cold reset mid frame
    run_frame("R8 cold reset frame", 100);
    run_frame("R8 invalid after cold", -1);

    // R3 random mix
    for (int n = 0; n < 24; n++) begin
      rand_inputs();
      run_frame("R3 random frame", (n % 9 == 8) ? 50 : -1);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule